// File: doc/BRIEF.md
# MESI Coherence State Controller for a Private Cache

This block keeps the coherence state and address tag for every line of one private, direct-mapped cache that sits on a shared snooping bus. Each line is in one of four states: Modified (dirty, sole copy), Exclusive (clean, sole copy), Shared (clean, possibly held elsewhere) or Invalid. The block serves two sources. The local processor sends read and write requests, and the block finds the hit or miss itself from its tag array. Other agents' bus transactions are snooped as reads, reads-for-ownership or invalidates.

For a processor request, the block reports whether the request hits, the state the line is in, and the state it moves to. It also names the bus transaction the request needs, if any. When a miss replaces a dirty line, it raises an eviction request and gives the victim's address. For a snooped transaction, it drives a shared response and raises a write-back request when its dirty copy must be supplied. The state change happens at the next clock edge.

The block holds no data, does no bus arbitration and does not model memory. The surrounding logic handles those and carries out the requests the block raises in the cycle they are shown. Lookups need no valid strobe, so the address inputs can also be used to read a line's state without changing it.

Top module: `mesi_line_ctrl`

## Requirements
- R1: After reset every line is Invalid. A lookup of any address reports a miss with state code 00, and no bus request or write-back is raised.
- R2: Line states are coded as Invalid=00, Shared=01, Exclusive=10 and Modified=11. A local read miss issues a bus read (op code 0) and fills the line as Exclusive when `bus_shared_in` is low, or as Shared when it is high, in that request's cycle.
- R3: A local write miss issues a read-for-ownership (op code 1) and moves the line to Modified.
- R4: A local write that hits an Exclusive line moves it to Modified with no bus request.
- R5: A local write that hits a Shared line issues an upgrade (op code 2) and moves the line to Modified.
- R6: A local write hit on Modified, and a read hit on Modified, Exclusive or Shared, leaves the state unchanged and issues no bus request.
- R7: A snooped read-for-ownership (snoop code 1) or invalidate (snoop code 2) whose tag matches a valid line makes that line Invalid. A read-for-ownership that matches a Modified line also raises `wb_snoop` in that cycle.
- R8: A snooped read (snoop code 0) whose tag matches a valid line raises `shared_out` in the same cycle. A Modified line also raises `wb_snoop`, and a Modified or Exclusive line becomes Shared. A snoop whose tag does not match leaves the line unchanged and raises no response.
- R9: When a snoop and a local request reach the same line in one cycle, the snoop is applied first, and the local request sees the state the snoop leaves.
- R10: A local miss on a line held Modified under another tag raises `evict_req` in that cycle, with `evict_addr` giving the victim's full address.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| cpu_req_valid | input | 1 | Local request present this cycle |
| cpu_req_write | input | 1 | 1 = write, 0 = read |
| cpu_req_addr | input | ADDR_W | Line address {tag, index} |
| bus_shared_in | input | 1 | Shared signal sampled for a read fill |
| snoop_valid | input | 1 | Snooped transaction present |
| snoop_op | input | 2 | 0 read, 1 read-for-ownership, 2 invalidate |
| snoop_addr | input | ADDR_W | Snooped line address {tag, index} |
| cpu_hit | output | 1 | Local address hits a valid line |
| cpu_cur_state | output | 2 | State seen by the local request (after any snoop) |
| cpu_next_state | output | 2 | State the line takes after the local request |
| bus_req_valid | output | 1 | Bus transaction required |
| bus_req_op | output | 2 | 0 read, 1 read-for-ownership, 2 upgrade |
| shared_out | output | 1 | Shared response to a snooped read |
| wb_snoop | output | 1 | Dirty data must be supplied for the snoop |
| evict_req | output | 1 | Dirty victim must be written back |
| evict_addr | output | ADDR_W | Address of the dirty victim |

## Verification
The embedded properties check every cycle that each processor write leaves its line Modified and each read fill lands in Exclusive or Shared according to the sampled shared signal. They also check that a matching kill snoop leaves the line Invalid, that a snoop-forced write-back leaves no Modified copy behind, and that the bus op code is never the unused value. Other behaviour depends on a particular order of events, and only the bench's scenarios show it. This covers which bus op each miss or upgrade chooses, that the Exclusive-to-Modified step is silent, the victim address on eviction, that a mismatching snoop leaves the line alone, and the snoop-first resolution when both sources reach one line together.

// File: rtl/mesi_line_ctrl.sv
module mesi_line_ctrl #(
  parameter int LINES = 8,
  parameter int TAG_W = 6,
  localparam int IDX_W = $clog2(LINES),
  localparam int ADDR_W = TAG_W + IDX_W
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              cpu_req_valid,
  input  logic              cpu_req_write,
  input  logic [ADDR_W-1:0] cpu_req_addr,
  input  logic              bus_shared_in,
  input  logic              snoop_valid,
  input  logic [1:0]        snoop_op,
  input  logic [ADDR_W-1:0] snoop_addr,
  output logic              cpu_hit,
  output logic [1:0]        cpu_cur_state,
  output logic [1:0]        cpu_next_state,
  output logic              bus_req_valid,
  output logic [1:0]        bus_req_op,
  output logic              shared_out,
  output logic              wb_snoop,
  output logic              evict_req,
  output logic [ADDR_W-1:0] evict_addr
);
  localparam logic [1:0] ST_I = 2'b00, ST_S = 2'b01, ST_E = 2'b10, ST_M = 2'b11;
  localparam logic [1:0] SN_RD = 2'd0, SN_RFO = 2'd1, SN_INV = 2'd2;
  localparam logic [1:0] BQ_RD = 2'd0, BQ_RDX = 2'd1, BQ_UPG = 2'd2;

  logic [1:0]       st   [LINES];
  logic [TAG_W-1:0] tags [LINES];

  logic [IDX_W-1:0] s_idx, c_idx;
  logic [TAG_W-1:0] s_tag, c_tag;
  logic [1:0]       s_st, s_next;
  logic             s_hit, same_line, need_bus;
  logic [1:0]       req_op;

  assign s_idx = snoop_addr[IDX_W-1:0];
  assign s_tag = snoop_addr[ADDR_W-1:IDX_W];
  assign c_idx = cpu_req_addr[IDX_W-1:0];
  assign c_tag = cpu_req_addr[ADDR_W-1:IDX_W];

  assign s_st  = st[s_idx];
  assign s_hit = snoop_valid && (s_st != ST_I) && (tags[s_idx] == s_tag);

  always_comb begin
    s_next = s_st;
    case (snoop_op)
      SN_RD:          if (s_st == ST_M || s_st == ST_E) s_next = ST_S;
      SN_RFO, SN_INV: s_next = ST_I;
      default:        s_next = s_st;
    endcase
  end

  assign shared_out = s_hit && (snoop_op == SN_RD);
  assign wb_snoop   = s_hit && (s_st == ST_M) && (snoop_op == SN_RD || snoop_op == SN_RFO);

  assign same_line     = s_hit && (s_idx == c_idx);
  assign cpu_cur_state = same_line ? s_next : st[c_idx];
  assign cpu_hit       = (cpu_cur_state != ST_I) && (tags[c_idx] == c_tag);

  always_comb begin
    cpu_next_state = cpu_cur_state;
    need_bus = 1'b0;
    req_op   = BQ_RD;
    if (!cpu_req_write) begin
      if (!cpu_hit) begin
        need_bus = 1'b1;
        req_op   = BQ_RD;
        cpu_next_state = bus_shared_in ? ST_S : ST_E;
      end
    end else if (!cpu_hit) begin
      need_bus = 1'b1;
      req_op   = BQ_RDX;
      cpu_next_state = ST_M;
    end else if (cpu_cur_state == ST_S) begin
      need_bus = 1'b1;
      req_op   = BQ_UPG;
      cpu_next_state = ST_M;
    end else begin
      cpu_next_state = ST_M;
    end
  end

  assign bus_req_valid = cpu_req_valid && need_bus;
  assign bus_req_op    = req_op;
  assign evict_req     = cpu_req_valid && !cpu_hit && (cpu_cur_state == ST_M);
  assign evict_addr    = {tags[c_idx], c_idx};

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      for (int i = 0; i < LINES; i++) begin
        st[i]   <= ST_I;
        tags[i] <= '0;
      end
    end else begin
      if (s_hit) st[s_idx] <= s_next;
      if (cpu_req_valid) begin
        st[c_idx] <= cpu_next_state;
        if (!cpu_hit) tags[c_idx] <= c_tag;
      end
    end
  end

  AST_WRITE_ENDS_M: assert property (@(posedge clk) disable iff (!rst_n)
    cpu_req_valid && cpu_req_write |=> st[$past(c_idx)] == ST_M); // R3

  AST_FILL_BY_SHARED: assert property (@(posedge clk) disable iff (!rst_n)
    cpu_req_valid && !cpu_req_write && !cpu_hit
    |=> st[$past(c_idx)] == ($past(bus_shared_in) ? ST_S : ST_E)); // R2

  AST_KILL_SNOOP: assert property (@(posedge clk) disable iff (!rst_n)
    s_hit && (snoop_op == SN_RFO || snoop_op == SN_INV) && !(cpu_req_valid && c_idx == s_idx)
    |=> st[$past(s_idx)] == ST_I); // R7

  AST_WB_LEAVES_CLEAN: assert property (@(posedge clk) disable iff (!rst_n)
    wb_snoop && !(cpu_req_valid && c_idx == s_idx) |=> st[$past(s_idx)] != ST_M); // R8

  AST_BUS_OP_LEGAL: assert property (@(posedge clk) disable iff (!rst_n)
    bus_req_valid |-> bus_req_op != 2'd3); // R5
endmodule

// File: tb/mesi_line_ctrl_tb.sv
module mesi_line_ctrl_tb;
  localparam int CLK_PERIOD = 10;
  localparam int LINES = 8;
  localparam int TAG_W = 6;
  localparam int IDX_W = $clog2(LINES);
  localparam int ADDR_W = TAG_W + IDX_W;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic cpu_req_valid = 1'b0, cpu_req_write = 1'b0, bus_shared_in = 1'b0, snoop_valid = 1'b0;
  logic [ADDR_W-1:0] cpu_req_addr = '0, snoop_addr = '0;
  logic [1:0] snoop_op = 2'd0;
  logic cpu_hit, bus_req_valid, shared_out, wb_snoop, evict_req;
  logic [1:0] cpu_cur_state, cpu_next_state, bus_req_op;
  logic [ADDR_W-1:0] evict_addr;

  int checks = 0;
  int errors = 0;
  bit done = 1'b0;

  always #(CLK_PERIOD/2) clk = ~clk;

  mesi_line_ctrl #(.LINES(LINES), .TAG_W(TAG_W)) u_dut (
    .clk(clk), .rst_n(rst_n), .cpu_req_valid(cpu_req_valid), .cpu_req_write(cpu_req_write),
    .cpu_req_addr(cpu_req_addr), .bus_shared_in(bus_shared_in), .snoop_valid(snoop_valid),
    .snoop_op(snoop_op), .snoop_addr(snoop_addr), .cpu_hit(cpu_hit),
    .cpu_cur_state(cpu_cur_state), .cpu_next_state(cpu_next_state),
    .bus_req_valid(bus_req_valid), .bus_req_op(bus_req_op), .shared_out(shared_out),
    .wb_snoop(wb_snoop), .evict_req(evict_req), .evict_addr(evict_addr));

  function automatic logic [ADDR_W-1:0] mk(int tag, int idx);
    return ADDR_W'((tag << IDX_W) | idx);
  endfunction

  task automatic chk(string req, int act, int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s: actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic probe(string req, logic [ADDR_W-1:0] a, int hit, int st);
    @(negedge clk);
    cpu_req_valid = 1'b0; snoop_valid = 1'b0; cpu_req_addr = a;
    #1;
    chk({req, " hit"}, cpu_hit, hit);
    chk({req, " state"}, cpu_cur_state, st);
  endtask

  task automatic cpu_go(logic wr, logic [ADDR_W-1:0] a, logic sh);
    @(negedge clk);
    snoop_valid = 1'b0;
    cpu_req_valid = 1'b1; cpu_req_write = wr; cpu_req_addr = a; bus_shared_in = sh;
    #1;
  endtask

  task automatic snoop_go(logic [1:0] op, logic [ADDR_W-1:0] a);
    @(negedge clk);
    cpu_req_valid = 1'b0;
    snoop_valid = 1'b1; snoop_op = op; snoop_addr = a;
    #1;
  endtask

  task automatic commit();
    @(posedge clk);
    #1;
    cpu_req_valid = 1'b0; snoop_valid = 1'b0; bus_shared_in = 1'b0;
  endtask

  task automatic t_reset();
    probe("R1", mk(9, 5), 0, 0);
    chk("R1 no bus", bus_req_valid, 0);
    chk("R1 no wb", wb_snoop, 0);
    chk("R1 no evict", evict_req, 0);
  endtask

  task automatic t_read_fill();
    cpu_go(1'b0, mk(1, 1), 1'b0);
    chk("R2 bus", bus_req_valid, 1); chk("R2 op", bus_req_op, 0); chk("R2 next E", cpu_next_state, 2);
    commit();
    probe("R2 E", mk(1, 1), 1, 2);
    cpu_go(1'b0, mk(2, 2), 1'b1);
    chk("R2 next S", cpu_next_state, 1);
    commit();
    probe("R2 S", mk(2, 2), 1, 1);
    cpu_go(1'b0, mk(1, 1), 1'b0);
    chk("R6 read hit bus", bus_req_valid, 0); chk("R6 read hit next", cpu_next_state, 2);
    commit();
  endtask

  task automatic t_writes();
    cpu_go(1'b1, mk(1, 1), 1'b0);
    chk("R4 silent", bus_req_valid, 0); chk("R4 next M", cpu_next_state, 3);
    commit();
    probe("R4 M", mk(1, 1), 1, 3);
    cpu_go(1'b1, mk(1, 1), 1'b0);
    chk("R6 M write bus", bus_req_valid, 0); chk("R6 M next", cpu_next_state, 3);
    commit();
    cpu_go(1'b1, mk(2, 2), 1'b0);
    chk("R5 bus", bus_req_valid, 1); chk("R5 op", bus_req_op, 2); chk("R5 next", cpu_next_state, 3);
    commit();
    probe("R5 M", mk(2, 2), 1, 3);
    cpu_go(1'b1, mk(3, 3), 1'b0);
    chk("R3 bus", bus_req_valid, 1); chk("R3 op", bus_req_op, 1); chk("R3 next", cpu_next_state, 3);
    chk("R3 no evict", evict_req, 0);
    commit();
    probe("R3 M", mk(3, 3), 1, 3);
  endtask

  task automatic t_evict();
    cpu_go(1'b0, mk(5, 3), 1'b0);
    chk("R10 evict", evict_req, 1); chk("R10 addr", evict_addr, mk(3, 3));
    chk("R10 op", bus_req_op, 0); chk("R10 next", cpu_next_state, 2);
    commit();
    probe("R10 old gone", mk(3, 3), 0, 2);
    probe("R10 new E", mk(5, 3), 1, 2);
  endtask

  task automatic t_snoop_read();
    snoop_go(2'd0, mk(5, 3));
    chk("R8 E shared", shared_out, 1); chk("R8 E no wb", wb_snoop, 0);
    commit();
    probe("R8 E to S", mk(5, 3), 1, 1);
    snoop_go(2'd0, mk(1, 1));
    chk("R8 M shared", shared_out, 1); chk("R8 M wb", wb_snoop, 1);
    commit();
    probe("R8 M to S", mk(1, 1), 1, 1);
    snoop_go(2'd0, mk(7, 2));
    chk("R8 miss shared", shared_out, 0); chk("R8 miss wb", wb_snoop, 0);
    commit();
    probe("R8 miss untouched", mk(2, 2), 1, 3);
  endtask

  task automatic t_snoop_kill();
    snoop_go(2'd1, mk(2, 2));
    chk("R7 rfo wb", wb_snoop, 1); chk("R7 rfo shared", shared_out, 0);
    commit();
    probe("R7 rfo I", mk(2, 2), 0, 0);
    snoop_go(2'd2, mk(5, 3));
    chk("R7 inv wb", wb_snoop, 0);
    commit();
    probe("R7 inv I", mk(5, 3), 0, 0);
  endtask

  task automatic t_same_cycle();
    cpu_go(1'b0, mk(4, 4), 1'b0);
    commit();
    @(negedge clk);
    snoop_valid = 1'b1; snoop_op = 2'd2; snoop_addr = mk(4, 4);
    cpu_req_valid = 1'b1; cpu_req_write = 1'b1; cpu_req_addr = mk(4, 4);
    #1;
    chk("R9 sees miss", cpu_hit, 0); chk("R9 op rdx", bus_req_op, 1);
    chk("R9 bus", bus_req_valid, 1); chk("R9 next", cpu_next_state, 3);
    commit();
    probe("R9 final M", mk(4, 4), 1, 3);
  endtask

  initial begin
    repeat (3) @(posedge clk);
    #1 rst_n = 1'b1;
    t_reset();
    t_read_fill();
    t_writes();
    t_evict();
    t_snoop_read();
    t_snoop_kill();
    t_same_cycle();
    if (!done) begin
      done = 1'b1;
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end

  initial begin
    #(CLK_PERIOD * 5000);
    if (!done) begin
      done = 1'b1;
      checks++; errors++;
      $display("FAIL watchdog: actual=timeout expected=finish");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end
endmodule